// File: doc/BRIEF.md
# Four-Channel Converter Write Decoder

This block sits between an 8-bit processor write bus and four 12-bit converter channels, each of which keeps two ranks of storage. A write lands in a channel's first rank, as either a low byte or a high nibble. All four second-rank registers, which drive the converter codes, reload together on a transfer. The processor can therefore stage new codes channel by channel and move every output in the same clock cycle. The higher address bits are decoded outside this block; it sees only a chip select that is already qualified and a short offset address.

An elaboration parameter picks one of three address maps. In the broadcast map, offset bit 3 set means "transfer all". In the last-byte map, the low-byte write to the highest channel also performs the transfer. The single-channel map drives channel 0 only: one address loads the byte, and another loads the nibble and transfers in the same write. A small access state machine turns every bus write into exactly one decode, however long the strobes stay low. It has two states. IDLE takes the edge IDLE->HOLD when select and write are both low, and that edge is the only one that decodes. HOLD takes HOLD->HOLD while both strobes stay low, and HOLD->IDLE when either one rises. The state machine also registers a one-cycle update flag.

Top module: `quad_dac_loader`

## Requirements
- R1: While the active-low reset is low, and asynchronously to the clock, every channel code reads 0x800 and upd_o reads 1. The first rank resets to 0x800 as well. upd_o falls at the first clock edge after release unless that edge transfers.
- R2: A write is taken only at a rising edge where cs_ni and wr_ni are both low and the state machine is in IDLE. Holding both low for further cycles, even with new address or data, has no effect until either strobe has risen.
- R3: Broadcast map: with addr_i[3]=0, addr_i[2:1] selects the channel (0 to 3), and addr_i[0]=0 loads data_i[7:0] into that channel's first-rank bits 7:0.
- R4: With addr_i[0]=1 (broadcast and last-byte maps), data_i[3:0] is loaded into first-rank bits 11:8 and data_i[7:4] is ignored.
- R5: A write that does not transfer leaves every channel code unchanged.
- R6: Broadcast map: a write with addr_i[3]=1 copies every channel's first rank into its code at the same edge, whatever the values of addr_i[2:0] and data_i.
- R7: upd_o is 1 in exactly the cycle after an edge that performed a transfer, and 0 in the cycle after any other edge (outside reset).
- R8: Last-byte map: a low-byte write to channel 3 (addr_i=4'b0110) loads that byte and transfers all channels in the same write, so the new byte is visible at once. Any write with addr_i[3]=1 is ignored.
- R9: Single-channel map: addr_i=4'b0010 loads the low byte of channel 0, and addr_i=4'b0001 loads its high nibble (data_i[3:0]) and transfers in the same write. Every other address is ignored, and channels 1 to 3 stay at 0x800.
- R10: A transfer with no new first-rank writes reproduces the previous codes, because the first rank keeps its contents after a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select (base region already decoded) |
| wr_ni | input | 1 | Active-low write strobe |
| addr_i | input | 4 | Offset address |
| data_i | input | 8 | Write data, right-justified |
| codes_o | output | 48 | Channel codes, channel k at bits 12k+11:12k |
| upd_o | output | 1 | One-cycle flag after a transfer, and high during reset |

## Verification
The hardest case to reach from the ports is a write held low over several clock edges while the address and data change. Only the first edge may decode, so a design that re-decodes in HOLD corrupts a first rank without any visible effect until a later transfer. The stimulus holds the strobes for several cycles with inverted data, and later issues a transfer that exposes any stray load. Random address and data are mixed with cycles where only one of the two strobes is low. The same bus drives all three address maps in parallel, so each write is checked against three independent expectations.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;

    // Address map selected at elaboration
    typedef enum logic [1:0] {
        MAP_BCAST    = 2'd0,  // offset top bit requests a global transfer
        MAP_LASTBYTE = 2'd1,  // last channel's low byte triggers the transfer
        MAP_SINGLE   = 2'd2   // one channel, nibble write transfers
    } map_mode_e;

    // Access state machine
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } acc_state_e;

endpackage

// File: rtl/qdl_access_fsm.sv
module qdl_access_fsm
    import quad_dac_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cs_ni,
    input  logic wr_ni,
    input  logic xfer_i,
    output logic accept_o,
    output logic upd_o
);

    acc_state_e state_q, state_d;
    logic       bus_req;
    logic       upd_q;

    assign bus_req = !cs_ni && !wr_ni;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bus_req)  state_d = ST_HOLD;
            ST_HOLD: if (!bus_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // outputs: decode enable from the idle state, registered update flag
    always_comb begin
        accept_o = 1'b0;
        unique case (state_q)
            ST_IDLE: accept_o = bus_req;
            ST_HOLD: accept_o = 1'b0;
            default: accept_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) upd_q <= 1'b1;
        else         upd_q <= xfer_i;
    end

    assign upd_o = upd_q;

endmodule

// File: rtl/qdl_addr_decode.sv
module qdl_addr_decode
    import quad_dac_pkg::*;
#(
    parameter map_mode_e MODE   = MAP_BCAST,
    parameter int        NUM_CH = 4,
    parameter int        ADDR_W = $clog2(NUM_CH) + 2
) (
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NUM_CH-1:0] byte_ld_o,
    output logic [NUM_CH-1:0] nib_ld_o,
    output logic              xfer_o
);

    localparam int SEL_W = $clog2(NUM_CH);
    localparam logic [SEL_W-1:0]  LAST_CH  = SEL_W'(NUM_CH - 1);
    localparam logic [ADDR_W-1:0] SG_BYTE  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] SG_NIB   = ADDR_W'(1);

    logic             top_bit;
    logic [SEL_W-1:0] ch_sel;
    logic             hi_sel;

    assign top_bit = addr_i[ADDR_W-1];
    assign ch_sel  = addr_i[ADDR_W-2:1];
    assign hi_sel  = addr_i[0];

    always_comb begin
        byte_ld_o = '0;
        nib_ld_o  = '0;
        xfer_o    = 1'b0;
        if (accept_i) begin
            unique case (MODE)
                MAP_BCAST: begin
                    if (top_bit)     xfer_o            = 1'b1;
                    else if (hi_sel) nib_ld_o[ch_sel]  = 1'b1;
                    else             byte_ld_o[ch_sel] = 1'b1;
                end
                MAP_LASTBYTE: begin
                    if (!top_bit) begin
                        if (hi_sel) begin
                            nib_ld_o[ch_sel] = 1'b1;
                        end else begin
                            byte_ld_o[ch_sel] = 1'b1;
                            xfer_o = (ch_sel == LAST_CH);
                        end
                    end
                end
                MAP_SINGLE: begin
                    if (addr_i == SG_BYTE) begin
                        byte_ld_o[0] = 1'b1;
                    end else if (addr_i == SG_NIB) begin
                        nib_ld_o[0] = 1'b1;
                        xfer_o      = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/qdl_channel.sv
module qdl_channel #(
    parameter int CODE_W = 12,
    parameter int BUS_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              byte_ld_i,
    input  logic              nib_ld_i,
    input  logic              xfer_i,
    input  logic [BUS_W-1:0]  data_i,
    output logic [CODE_W-1:0] code_o
);

    localparam int HI_W = CODE_W - BUS_W;
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    logic [BUS_W-1:0]  lo_q, lo_d;
    logic [HI_W-1:0]   hi_q, hi_d;
    logic [CODE_W-1:0] code_q;

    // the transfer sees the value being written in the same cycle
    assign lo_d = byte_ld_i ? data_i : lo_q;
    assign hi_d = nib_ld_i ? data_i[HI_W-1:0] : hi_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lo_q   <= MID[BUS_W-1:0];
            hi_q   <= MID[CODE_W-1:BUS_W];
            code_q <= MID;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
            if (xfer_i) code_q <= {hi_d, lo_d};
        end
    end

    assign code_o = code_q;

endmodule

// File: rtl/quad_dac_loader.sv
module quad_dac_loader
    import quad_dac_pkg::*;
#(
    parameter map_mode_e MODE   = MAP_BCAST,
    parameter int        NUM_CH = 4,
    parameter int        CODE_W = 12,
    parameter int        BUS_W  = 8,
    parameter int        ADDR_W = $clog2(NUM_CH) + 2
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     cs_ni,
    input  logic                     wr_ni,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [BUS_W-1:0]         data_i,
    output logic [NUM_CH*CODE_W-1:0] codes_o,
    output logic                     upd_o
);

    logic              accept;
    logic              xfer;
    logic [NUM_CH-1:0] byte_ld;
    logic [NUM_CH-1:0] nib_ld;

    qdl_access_fsm u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cs_ni    (cs_ni),
        .wr_ni    (wr_ni),
        .xfer_i   (xfer),
        .accept_o (accept),
        .upd_o    (upd_o)
    );

    qdl_addr_decode #(
        .MODE   (MODE),
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .accept_i  (accept),
        .addr_i    (addr_i),
        .byte_ld_o (byte_ld),
        .nib_ld_o  (nib_ld),
        .xfer_o    (xfer)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        qdl_channel #(
            .CODE_W (CODE_W),
            .BUS_W  (BUS_W)
        ) u_ch (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .byte_ld_i (byte_ld[k]),
            .nib_ld_i  (nib_ld[k]),
            .xfer_i    (xfer),
            .data_i    (data_i),
            .code_o    (codes_o[k*CODE_W +: CODE_W])
        );
    end

endmodule

// File: rtl/qdl_checker.sv
module qdl_checker #(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 12
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     cs_ni,
    input logic                     wr_ni,
    input logic                     accept,
    input logic                     xfer,
    input logic [NUM_CH-1:0]        byte_ld,
    input logic [NUM_CH-1:0]        nib_ld,
    input logic [NUM_CH*CODE_W-1:0] codes_o,
    input logic                     upd_o
);

    AST_ACCEPT_NEEDS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept |-> (!cs_ni && !wr_ni)); // R2

    AST_ONE_DECODE_PER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept |=> !accept); // R2

    AST_STROBE_NEEDS_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|byte_ld) || (|nib_ld) || xfer) |-> accept); // R2

    AST_SINGLE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({byte_ld, nib_ld}) <= 1); // R3

    AST_CODES_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !xfer |=> $stable(codes_o)); // R5

    AST_FLAG_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xfer |=> upd_o); // R7

    AST_FLAG_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !xfer |=> !upd_o); // R7

endmodule

bind quad_dac_loader qdl_checker #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W)
) u_qdl_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .wr_ni   (wr_ni),
    .accept  (accept),
    .xfer    (xfer),
    .byte_ld (byte_ld),
    .nib_ld  (nib_ld),
    .codes_o (codes_o),
    .upd_o   (upd_o)
);

// File: tb/quad_dac_loader_bench.sv
`timescale 1ns/1ps
module quad_dac_loader_bench;
    import quad_dac_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic wr_n = 1'b1;
    logic [3:0] addr = '0;
    logic [7:0] data = '0;
    logic [47:0] codes_m [3];
    logic        upd_m   [3];

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // expected state per map (0 broadcast, 1 last-byte, 2 single) and channel
    logic [7:0]  e_lo  [3][4];
    logic [3:0]  e_hi  [3][4];
    logic [11:0] e_out [3][4];
    logic        e_upd [3];

    always #10 clk = ~clk;  // 50 MHz

    quad_dac_loader #(.MODE(MAP_BCAST)) u_quad_dac_loader (
        .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n),
        .addr_i(addr), .data_i(data), .codes_o(codes_m[0]), .upd_o(upd_m[0]));

    quad_dac_loader #(.MODE(MAP_LASTBYTE)) u_quad_dac_loader_lb (
        .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n),
        .addr_i(addr), .data_i(data), .codes_o(codes_m[1]), .upd_o(upd_m[1]));

    quad_dac_loader #(.MODE(MAP_SINGLE)) u_quad_dac_loader_sg (
        .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n),
        .addr_i(addr), .data_i(data), .codes_o(codes_m[2]), .upd_o(upd_m[2]));

    task automatic model_reset();
        for (int m = 0; m < 3; m++) begin
            for (int c = 0; c < 4; c++) begin
                e_lo[m][c]  = 8'h00;
                e_hi[m][c]  = 4'h8;
                e_out[m][c] = 12'h800;
            end
            e_upd[m] = 1'b1;
        end
    endtask

    task automatic model_write(input logic [3:0] a, input logic [7:0] d);
        for (int m = 0; m < 3; m++) begin
            int bch = -1;
            int nch = -1;
            bit xf  = 1'b0;
            if (m == 0) begin
                if (a[3]) xf = 1'b1;
                else if (a[0]) nch = int'(a[2:1]);
                else bch = int'(a[2:1]);
            end else if (m == 1) begin
                if (!a[3]) begin
                    if (a[0]) nch = int'(a[2:1]);
                    else begin
                        bch = int'(a[2:1]);
                        xf = (a[2:1] == 2'd3);
                    end
                end
            end else begin
                if (a == 4'b0010) bch = 0;
                else if (a == 4'b0001) begin nch = 0; xf = 1'b1; end
            end
            if (bch >= 0) e_lo[m][bch] = d;
            if (nch >= 0) e_hi[m][nch] = d[3:0];
            if (xf) for (int c = 0; c < 4; c++) e_out[m][c] = {e_hi[m][c], e_lo[m][c]};
            e_upd[m] = xf;
        end
    endtask

    task automatic clear_upd();
        for (int m = 0; m < 3; m++) e_upd[m] = 1'b0;
    endtask

    task automatic check_all(input string tag);
        for (int m = 0; m < 3; m++) begin
            for (int c = 0; c < 4; c++) begin
                n_chk++;
                if (codes_m[m][c*12 +: 12] !== e_out[m][c]) begin
                    n_bad++;
                    $display("FAIL %s map%0d ch%0d code: got %h expected %h",
                             tag, m, c, codes_m[m][c*12 +: 12], e_out[m][c]);
                end
            end
            n_chk++;
            if (upd_m[m] !== e_upd[m]) begin
                n_bad++;
                $display("FAIL %s map%0d upd: got %b expected %b", tag, m, upd_m[m], e_upd[m]);
            end
        end
    endtask

    // one bus write; optional extra held cycles with altered address and data
    task automatic bus_write(input logic [3:0] a, input logic [7:0] d,
                             input int hold, input string tag);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; data = d;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        check_all(tag);
        for (int h = 0; h < hold; h++) begin
            addr = ~a; data = ~d;
            @(negedge clk);
            clear_upd();
            check_all("R2 held strobes");
        end
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        clear_upd();
        check_all("R7 flag drop");
    endtask

    // a cycle with only one strobe low: nothing may happen
    task automatic half_strobe(input bit which, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = which; wr_n = !which; addr = a; data = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        clear_upd();
        check_all("R2 half strobe");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd51277);
        model_reset();
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        clear_upd();
        check_all("R1 after release");

        // R3 R4 R5 first-rank loads in every channel, no code change
        bus_write(4'b0000, 8'hAB, 0, "R3 byte ch0");
        bus_write(4'b0001, 8'h5C, 0, "R4 nibble ch0 upper ignored");
        bus_write(4'b0010, 8'h12, 0, "R3 byte ch1");
        bus_write(4'b0011, 8'hF7, 0, "R4 nibble ch1");
        bus_write(4'b0101, 8'h3E, 0, "R5 nibble ch2");
        bus_write(4'b0111, 8'h09, 0, "R5 nibble ch3");
        bus_write(4'b1011, 8'hFF, 0, "R6 broadcast");
        bus_write(4'b1000, 8'h00, 0, "R10 repeat transfer");
        // R8 last-byte map transfers on channel 3 byte
        bus_write(4'b0100, 8'h77, 0, "R5 byte ch2");
        bus_write(4'b0110, 8'hC4, 0, "R8 byte ch3 transfer");
        bus_write(4'b1110, 8'h21, 0, "R8 top bit ignored");
        // R9 single-channel map
        bus_write(4'b0010, 8'h5A, 0, "R9 single byte");
        bus_write(4'b0001, 8'hE3, 0, "R9 single nibble transfer");
        bus_write(4'b0000, 8'h99, 0, "R9 unused 0");
        bus_write(4'b0011, 8'h66, 0, "R9 unused 3");
        // R2 held strobes, then transfers expose any stray load
        bus_write(4'b0000, 8'h3C, 4, "R2 held write");
        bus_write(4'b0001, 8'h4A, 3, "R2 held nibble");
        half_strobe(1'b0, 4'b1000, 8'h00);
        half_strobe(1'b1, 4'b0000, 8'hEE);
        bus_write(4'b1000, 8'h00, 0, "R2 R6 exposing transfer");
        bus_write(4'b0110, 8'h81, 0, "R8 exposing transfer");

        for (int i = 0; i < 400; i++) begin
            logic [3:0] ra = 4'($urandom);
            logic [7:0] rd = 8'($urandom);
            if ($urandom % 5 == 0) half_strobe(1'($urandom), ra, rd);
            else bus_write(ra, rd, int'($urandom % 3), "R3 R4 R6 random");
        end

        // R1 asynchronous reset mid-run
        @(negedge clk);
        #3 rst_n = 1'b0;
        #2 model_reset();
        check_all("R1 async reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        clear_upd();
        check_all("R1 after second release");
        bus_write(4'b1001, 8'h00, 0, "R1 R6 transfer of reset first rank");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule